// File: doc/BRIEF.md
# Prescaled Multi-Line Input Glitch Filter

This block conditions a set of asynchronous external interrupt pads before they reach an interrupt controller. Each pad is brought into the clock domain through a two-flop synchronizer. It then passes through a per-line counting filter that accepts a new level only after the synchronized input has stayed at that level for a programmed number of filter ticks. A single programmable prescaler, shared by all lines, derives the filter tick from the peripheral clock.

A line runs in all-pass mode when its filter is disabled or when its limit is 0, 1 or 2. In that mode the synchronized level goes straight to the output register. For limits of 3 to 15 a short pulse on the pad is dropped. A level that holds long enough shows up after roughly `limit` ticks. The exact delay depends on where the first tick falls relative to the input change, so it can be up to one tick period shorter than `limit` tick periods. Every change of the filtered level also produces a one-clock rising or falling pulse, which the interrupt logic can use.

Top module: `pad_glitch_filter`

## Requirements
- R1: While `rst` is high, `level_out`, `rise_out` and `fall_out` are all zero, whatever the pads do.
- R2: The filter tick repeats every `prescale`+1 clock cycles. A new `prescale` value is taken at the next tick boundary and is in use from then on.
- R3: With the filter enabled and a limit of 0, 1 or 2, a pad change shows up on `level_out` exactly 3 rising clock edges after the edge on which it was first sampled: the edge that samples it and two more.
- R4: With `flt_en` low for a line, the line is all-pass with the same 3-edge latency as in R3, whatever its limit.
- R5: With the filter enabled and a limit m from 3 to 15, and a prescale value p (so P = p+1), a held pad change reaches `level_out` between (m-1)*P+3 and m*P+2 edges after the change is driven. When p = 0 the latency is exactly m+2 edges.
- R6: When p = 0 and the limit is m (3 to 15), a pad pulse that lasts m-1 clock cycles never reaches `level_out`, and a pulse that lasts m cycles does.
- R7: `rise_out[i]` is high for exactly the one clock cycle in which `level_out[i]` first reads 1 after a 0.
- R8: `fall_out[i]` is high for exactly the one clock cycle in which `level_out[i]` first reads 0 after a 1. A line never shows a rising and a falling pulse at the same time.
- R9: Lines are independent. Activity on one pad, and the settings of one line, do not change the outputs of another line.
- R10: Line i takes its 4-bit limit from `max_cnt[4*i+3:4*i]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| pad_in | input | LINES | Raw asynchronous pad levels |
| prescale | input | PRE_W | Tick divider; one tick every prescale+1 cycles |
| flt_en | input | LINES | Per-line filter enable |
| max_cnt | input | LINES*CNT_W | Per-line limit, packed 4 bits per line, line 0 at the bottom |
| level_out | output | LINES | Filtered, registered line levels |
| rise_out | output | LINES | One-cycle pulse on each rising edge of the filtered level |
| fall_out | output | LINES | One-cycle pulse on each falling edge of the filtered level |

## Verification
Each pad change is driven just after a falling clock edge, and the bench counts rising edges until `level_out` takes the new value. It samples 1 ns after each edge.

- In all-pass mode the result is due on the third edge: two synchronizer flops and the output register.
- With p = 0 a tick occurs on every edge, so a filtered result is due exactly m+2 edges after the change.
- With larger prescale values, where the tick phase is not known, the latency is checked against the window [(m-1)*P+3, m*P+2].

The edge pulses are checked in the same sample that first shows the new level, and again one cycle later, when they must have cleared.

// File: rtl/pgf_pkg.sv
package pgf_pkg;
  localparam int SYNC_STAGES = 2;
  localparam int MIN_FILTERED = 3;

  function automatic logic is_allpass(input logic en, input logic [3:0] limit);
    return !en || (limit < 4'(MIN_FILTERED));
  endfunction
endpackage

// File: rtl/pgf_sync.sv
module pgf_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pgf_prescaler.sv
module pgf_prescaler #(
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] div_in,
  output logic          tick
);
  logic [PW-1:0] cnt_q;
  logic [PW-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      div_q <= '0;
      tick  <= 1'b0;
    end else if (cnt_q == div_q) begin
      cnt_q <= '0;
      div_q <= div_in;
      tick  <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      tick  <= 1'b0;
    end
  end

  // R2: the counter never runs past the divider that is in use
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= div_q);

  // R2: when the divider is nonzero, ticks are separated by idle cycles
  p_tick_gap_r2: assert property (@(posedge clk) disable iff (rst)
    (tick && div_q != '0) |=> !tick);

  // R2: the divider changes only right after a tick boundary
  p_div_at_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (div_q != $past(div_q)) |-> tick);
endmodule

// File: rtl/pgf_line.sv
module pgf_line
  import pgf_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          din,
  input  logic          en,
  input  logic [CW-1:0] limit,
  output logic          lvl,
  output logic          rise,
  output logic          fall
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nxt;
  logic          lvl_nxt;
  logic          allpass;
  logic [CW:0]   cnt_inc;

  assign allpass = is_allpass(en, 4'(limit));
  assign cnt_inc = {1'b0, cnt_q} + 1'b1;

  always_comb begin
    lvl_nxt = lvl;
    cnt_nxt = cnt_q;
    if (din == lvl) begin
      cnt_nxt = '0;
    end else if (allpass) begin
      lvl_nxt = din;
      cnt_nxt = '0;
    end else if (tick) begin
      if (cnt_inc >= {1'b0, limit}) begin
        lvl_nxt = din;
        cnt_nxt = '0;
      end else begin
        cnt_nxt = cnt_inc[CW-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      lvl   <= 1'b0;
      rise  <= 1'b0;
      fall  <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      lvl   <= lvl_nxt;
      rise  <= lvl_nxt & ~lvl;
      fall  <= ~lvl_nxt & lvl;
    end
  end

  // R3/R4: in all-pass mode a differing input is taken on the next edge
  p_allpass_r3: assert property (@(posedge clk) disable iff (rst)
    (allpass && din != lvl) |=> (lvl == $past(din)));

  // R5: in filtering mode the level holds through any cycle without a tick
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!allpass && !tick) |=> (lvl == $past(lvl)));

  // R5: the counter clears once the input agrees with the level
  p_cnt_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (din == lvl) |=> (cnt_q == '0));

  // R7: a rising pulse comes with a fresh 1 on the level
  p_rise_r7: assert property (@(posedge clk) disable iff (rst)
    rise |-> (lvl && !$past(lvl)));

  // R8: a falling pulse comes with a fresh 0, never together with a rise
  p_fall_r8: assert property (@(posedge clk) disable iff (rst)
    fall |-> (!lvl && $past(lvl)));

  p_edge_excl_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rise, fall}));
endmodule

// File: rtl/pad_glitch_filter.sv
module pad_glitch_filter
  import pgf_pkg::*;
#(
  parameter int LINES = 4,
  parameter int PRE_W = 4,
  parameter int CNT_W = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [LINES-1:0]       pad_in,
  input  logic [PRE_W-1:0]       prescale,
  input  logic [LINES-1:0]       flt_en,
  input  logic [LINES*CNT_W-1:0] max_cnt,
  output logic [LINES-1:0]       level_out,
  output logic [LINES-1:0]       rise_out,
  output logic [LINES-1:0]       fall_out
);
  logic [LINES-1:0] pad_sync;
  logic             tick;

  pgf_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pad_in),
    .q   (pad_sync)
  );

  pgf_prescaler #(.PW(PRE_W)) u_presc (
    .clk    (clk),
    .rst    (rst),
    .div_in (prescale),
    .tick   (tick)
  );

  // R10: line i reads its limit from bits [CNT_W*i +: CNT_W]
  for (genvar i = 0; i < LINES; i++) begin : g_line
    pgf_line #(.CW(CNT_W)) u_line (
      .clk   (clk),
      .rst   (rst),
      .tick  (tick),
      .din   (pad_sync[i]),
      .en    (flt_en[i]),
      .limit (max_cnt[CNT_W*i +: CNT_W]),
      .lvl   (level_out[i]),
      .rise  (rise_out[i]),
      .fall  (fall_out[i])
    );
  end

  // R1: the cycle after reset is seen, every output is quiet
  p_reset_r1: assert property (@(posedge clk)
    $past(rst) |-> (level_out == '0 && rise_out == '0 && fall_out == '0));
endmodule

// File: tb/test_pad_glitch_filter.sv
module test_pad_glitch_filter;
  localparam int N  = 4;
  localparam int PW = 4;
  localparam int CW = 4;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [N-1:0]    pad_in = '0;
  logic [PW-1:0]   prescale = '0;
  logic [N-1:0]    flt_en = '0;
  logic [N*CW-1:0] max_cnt = '0;
  logic [N-1:0]    level_out, rise_out, fall_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  pad_glitch_filter #(.LINES(N), .PRE_W(PW), .CNT_W(CW)) i_pad_glitch_filter (
    .clk (clk), .rst (rst), .pad_in (pad_in), .prescale (prescale),
    .flt_en (flt_en), .max_cnt (max_cnt),
    .level_out (level_out), .rise_out (rise_out), .fall_out (fall_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg(input int l, input logic en, input int m);
    flt_en[l] = en;
    max_cnt[l*CW +: CW] = CW'(m);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Drive a level on line l and count edges until level_out follows.
  // lat is 999 if the level never arrives. pulse_ok covers R7/R8.
  task automatic measure(input int l, input logic v, input string req,
                         output int lat, output bit pulse_ok);
    @(negedge clk);
    pad_in[l] = v;
    lat = 999;
    pulse_ok = 0;
    for (int n = 1; n <= 300; n++) begin
      @(posedge clk); #1;
      if (level_out[l] == v) begin
        lat = n;
        pulse_ok = v ? (rise_out[l] && !fall_out[l]) : (fall_out[l] && !rise_out[l]);
        break;
      end
    end
    @(posedge clk); #1;
    if (rise_out[l] || fall_out[l]) pulse_ok = 0;
    chk(pulse_ok, v ? {req, " R7 rise pulse"} : {req, " R8 fall pulse"},
        int'(pulse_ok), 1);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int lat;
    bit pok;

    // R1: outputs stay zero during reset, even with all pads high
    pad_in = '1;
    repeat (4) @(posedge clk);
    #1;
    chk(level_out == '0 && rise_out == '0 && fall_out == '0,
        "R1 reset outputs", int'(level_out), 0);
    @(negedge clk);
    pad_in = '0;
    idle(3);
    rst = 0;
    idle(5);
    #1;
    chk(level_out == '0, "R1 after release", int'(level_out), 0);

    // R3: limits 0..2 are all-pass, 3 edges, with prescale 2
    prescale = 4'd2;
    for (int m = 0; m <= 2; m++) begin
      cfg(0, 1'b1, m);
      idle(10);
      measure(0, 1'b1, "R3", lat, pok);
      chk(lat == 3, "R3 all-pass rise latency", lat, 3);
      measure(0, 1'b0, "R3", lat, pok);
      chk(lat == 3, "R3 all-pass fall latency", lat, 3);
    end

    // R4: a disabled line is all-pass whatever its limit
    cfg(1, 1'b0, 9);
    idle(4);
    measure(1, 1'b1, "R4", lat, pok);
    chk(lat == 3, "R4 disabled rise latency", lat, 3);
    measure(1, 1'b0, "R4", lat, pok);
    chk(lat == 3, "R4 disabled fall latency", lat, 3);

    // R5/R10: prescale 0 gives an exact latency of m+2, on each line
    prescale = 4'd0;
    idle(40);
    for (int l = 0; l < N; l++) begin
      for (int m = 3; m <= 8; m++) begin
        cfg(l, 1'b1, m);
        idle(3);
        measure(l, 1'b1, "R5", lat, pok);
        chk(lat == m + 2, "R5/R10 exact rise latency", lat, m + 2);
        measure(l, 1'b0, "R5", lat, pok);
        chk(lat == m + 2, "R5/R10 exact fall latency", lat, m + 2);
      end
    end
    cfg(0, 1'b1, 15);
    idle(3);
    measure(0, 1'b1, "R5", lat, pok);
    chk(lat == 17, "R5 limit 15 latency", lat, 17);
    measure(0, 1'b0, "R5", lat, pok);

    // R2/R5: prescale 3 (P=4) keeps latency inside the tick window
    prescale = 4'd3;
    idle(40);
    for (int m = 3; m <= 6; m++) begin
      cfg(2, 1'b1, m);
      idle(3);
      measure(2, 1'b1, "R2", lat, pok);
      chk(lat >= (m - 1) * 4 + 3 && lat <= m * 4 + 2,
          "R2/R5 window rise latency", lat, m * 4 + 2);
      measure(2, 1'b0, "R2", lat, pok);
      chk(lat >= (m - 1) * 4 + 3 && lat <= m * 4 + 2,
          "R2/R5 window fall latency", lat, m * 4 + 2);
    end

    // R2: a new prescale value is adopted at a boundary
    prescale = 4'd0;
    idle(20);
    cfg(2, 1'b1, 4);
    idle(3);
    measure(2, 1'b1, "R2", lat, pok);
    chk(lat == 6, "R2 prescale change adopted", lat, 6);
    measure(2, 1'b0, "R2", lat, pok);

    // R6: with limit 5, a 4-cycle pulse is dropped and a 5-cycle pulse passes
    for (int w = 4; w <= 5; w++) begin
      bit seen;
      seen = 0;
      cfg(3, 1'b1, 5);
      idle(5);
      @(negedge clk);
      pad_in[3] = 1'b1;
      repeat (w) @(negedge clk);
      pad_in[3] = 1'b0;
      for (int n = 0; n < 30; n++) begin
        @(posedge clk); #1;
        if (level_out[3]) seen = 1;
      end
      chk(seen == (w == 5), "R6 glitch filter pulse width", int'(seen), int'(w == 5));
    end

    // R9: lines 0 and 1 toggle while line 2 stays low
    prescale = 4'd1;
    cfg(0, 1'b1, 7);
    cfg(1, 1'b1, 0);
    cfg(2, 1'b1, 3);
    idle(10);
    measure(1, 1'b1, "R9", lat, pok);
    measure(0, 1'b1, "R9", lat, pok);
    chk(level_out == 4'b0011, "R9 line independence", int'(level_out), 3);
    measure(0, 1'b0, "R9", lat, pok);
    measure(1, 1'b0, "R9", lat, pok);
    chk(level_out == 4'b0000, "R9 lines back low", int'(level_out), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule